// File: doc/BRIEF.md
# HDLC Transmit Framer with Underrun Termination

This block turns a stream of host octets into a bit-serial HDLC line stream. Between frames it sends the flag octet back to back. Once the host has supplied octets, the block sends them as frame content. It accumulates a 16-bit frame check sequence over them and inserts a zero after every run of five ones inside the frame. The line advances one bit per strobe of `bit_en`, so the line rate is set entirely by whoever drives that strobe.

The host offers octets on `in_valid`/`in_data`, and a transfer happens on any clock where `host_cts` is high. A single holding register lets the next octet arrive while the current one shifts out. The frame has no explicit end marker. When the serializer finishes an octet and the holding register is empty, that moment ends the frame. The block then sends the complemented check sequence and a closing flag. `host_cts` stays low from that moment until the first closing flag has left the line. `host_cts` is also high for a short time after the last octet is taken, before the block notices the underrun. A host that raises an interrupt on `host_cts` should ignore that last request.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With no host data pending, the line carries the flag 0x7E continuously, sent least significant bit first, with no gap between flags. No stuffing bit is ever placed inside a flag.
- R2: An octet is taken on a clock where `in_valid` and `host_cts` are both high. `host_cts` is low while the holding register is occupied.
- R3: Within frame content (data and check sequence), a 0 is inserted after every five consecutive 1s on the line. This includes runs that cross an octet boundary and a run at the very end of the check sequence. The line never shows seven consecutive 1s.
- R4: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, preset 0xFFFF, processed least significant bit first over every data octet of the frame. It is sent one's-complemented, low octet first, each octet least significant bit first.
- R5: When the serializer finishes the last bit of a data octet and the holding register is empty, the frame ends. The two check-sequence octets follow immediately, and then a flag.
- R6: `host_cts` goes low at the end of a frame and stays low until the last bit of the first closing flag has been sent.
- R7: Outside the closing interval, `host_cts` is high whenever the holding register is empty. This includes the interval just before an underrun is detected.
- R8: The first data octet of a frame starts right after a flag boundary. Successive data octets follow each other with no flag or idle bit between them.
- R9: `line_bit` changes only on a clock where `bit_en` is high. Reset leaves `line_bit` at 1 and `host_cts` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit strobe; one line bit per high cycle |
| in_valid | input | 1 | Host offers an octet |
| in_data | input | 8 | Host octet |
| host_cts | output | 1 | Clear to send; high when the block takes an octet |
| line_bit | output | 1 | Serial HDLC line output |

## Verification
Frames are built from several octet patterns, and each pattern exposes a different kind of fault:
- Rising counts give dense, varied content.
- All-ones octets force a stuffing bit every five bits.
- All-zero octets produce no stuffing at all.
- Octets equal to the flag value show whether content is stuffed and never mistaken for a flag.
- An 0xF8/0x1F pair places a run of ones across an octet boundary.
- One-octet frames and back-to-back frames exercise the underrun timing and the closing-flag handshake.

The same patterns run with a strobe every fourth clock and with one on every clock. The received line is deframed and destuffed so that payload and check sequence can be compared against an independently computed CRC. A known nine-character string pins down the CRC convention.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int unsigned OCTET_W   = 8;
  localparam int unsigned FCS_W     = 2 * OCTET_W;
  localparam int unsigned RUN_LIMIT = 5;

  localparam logic [OCTET_W-1:0] FLAG_OCTET  = 8'h7E;
  localparam logic [FCS_W-1:0]   FCS_POLY_LF = 16'h8408;
  localparam logic [FCS_W-1:0]   FCS_PRESET  = 16'hFFFF;

  typedef enum logic [1:0] {
    SYM_FLAG   = 2'd0,
    SYM_DATA   = 2'd1,
    SYM_FCS_LO = 2'd2,
    SYM_FCS_HI = 2'd3
  } sym_e;

  // Fold one octet into the reflected CRC register, bit 0 first.
  function automatic logic [FCS_W-1:0] fcs_fold(input logic [FCS_W-1:0] acc,
                                                input logic [OCTET_W-1:0] octet);
    logic [FCS_W-1:0] c;
    c = acc;
    for (int i = 0; i < int'(OCTET_W); i++) begin
      if (c[0] ^ octet[i]) c = (c >> 1) ^ FCS_POLY_LF;
      else                 c = c >> 1;
    end
    return c;
  endfunction

  // Symbols whose bits are subject to zero insertion.
  function automatic logic is_content(input sym_e s);
    return s != SYM_FLAG;
  endfunction

endpackage

// File: rtl/hdlc_tx_holdbuf.sv
module hdlc_tx_holdbuf
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned W = OCTET_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         take,
  input  logic         closing,
  output logic         buf_valid,
  output logic [W-1:0] buf_data,
  output logic         host_cts
);

  logic accept;

  // Ready only when empty and not inside the closing interval.
  assign host_cts = !buf_valid && !closing;
  assign accept   = in_valid && host_cts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
    end else begin
      if (accept) begin
        buf_valid <= 1'b1;
        buf_data  <= in_data;
      end else if (take) begin
        buf_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned W  = OCTET_W,
  parameter int unsigned CW = FCS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed,
  input  logic          fold,
  input  logic [W-1:0]  octet,
  output logic [CW-1:0] acc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= FCS_PRESET;
    end else if (seed) begin
      acc <= fcs_fold(FCS_PRESET, octet);
    end else if (fold) begin
      acc <= fcs_fold(acc, octet);
    end
  end

endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned W   = OCTET_W,
  parameter int unsigned CW  = FCS_W,
  parameter int unsigned RUN = RUN_LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          buf_valid,
  input  logic [W-1:0]  buf_data,
  input  logic [CW-1:0] fcs_acc,
  output logic          line_bit,
  output logic          take,
  output logic          fcs_seed,
  output logic          fcs_step,
  output logic          closing,
  output sym_e          cur_sym,
  output logic          eof_evt,
  output logic          flag_done_evt,
  output logic          stuff_evt
);

  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned RUN_W = $clog2(RUN + 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] left_q;
  logic [RUN_W-1:0] ones_q;
  logic             shift_evt;
  logic             sym_done;
  sym_e             nxt_sym;
  logic [W-1:0]     nxt_sh;

  // Internal events.
  assign stuff_evt     = bit_en && (ones_q == RUN_W'(RUN));
  assign shift_evt     = bit_en && !stuff_evt;
  assign sym_done      = shift_evt && (left_q == CNT_W'(1));
  assign flag_done_evt = sym_done && (cur_sym == SYM_FLAG);

  // Choice of the next symbol at the last bit of the current one.
  always_comb begin
    nxt_sym  = cur_sym;
    nxt_sh   = sh_q;
    take     = 1'b0;
    fcs_seed = 1'b0;
    fcs_step = 1'b0;
    eof_evt  = 1'b0;
    if (sym_done) begin
      unique case (cur_sym)
        SYM_FLAG: begin
          if (buf_valid) begin
            nxt_sym  = SYM_DATA;
            nxt_sh   = buf_data;
            take     = 1'b1;
            fcs_seed = 1'b1;
          end else begin
            nxt_sym = SYM_FLAG;
            nxt_sh  = FLAG_OCTET;
          end
        end
        SYM_DATA: begin
          if (buf_valid) begin
            nxt_sym  = SYM_DATA;
            nxt_sh   = buf_data;
            take     = 1'b1;
            fcs_step = 1'b1;
          end else begin
            nxt_sym = SYM_FCS_LO;
            nxt_sh  = ~fcs_acc[W-1:0];
            eof_evt = 1'b1;
          end
        end
        SYM_FCS_LO: begin
          nxt_sym = SYM_FCS_HI;
          nxt_sh  = ~fcs_acc[CW-1:W];
        end
        default: begin
          nxt_sym = SYM_FLAG;
          nxt_sh  = FLAG_OCTET;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_sym  <= SYM_FLAG;
      sh_q     <= FLAG_OCTET;
      left_q   <= CNT_W'(W);
      ones_q   <= '0;
      line_bit <= 1'b1;
    end else if (stuff_evt) begin
      line_bit <= 1'b0;
      ones_q   <= '0;
    end else if (shift_evt) begin
      line_bit <= sh_q[0];
      if (is_content(cur_sym) && sh_q[0]) ones_q <= ones_q + 1'b1;
      else                                ones_q <= '0;
      if (sym_done) begin
        cur_sym <= nxt_sym;
        sh_q    <= nxt_sh;
        left_q  <= CNT_W'(W);
      end else begin
        sh_q   <= sh_q >> 1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             closing <= 1'b0;
    else if (eof_evt)       closing <= 1'b1;
    else if (flag_done_evt) closing <= 1'b0;
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned W  = OCTET_W,
  parameter int unsigned CW = FCS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         host_cts,
  output logic         line_bit
);

  logic          buf_valid;
  logic [W-1:0]  buf_data;
  logic          take;
  logic          closing;
  logic          fcs_seed;
  logic          fcs_step;
  logic [CW-1:0] fcs_acc;
  sym_e          cur_sym;
  logic          eof_evt;
  logic          flag_done_evt;
  logic          stuff_evt;

  hdlc_tx_holdbuf #(.W(W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .take      (take),
    .closing   (closing),
    .buf_valid (buf_valid),
    .buf_data  (buf_data),
    .host_cts  (host_cts)
  );

  hdlc_tx_fcs #(.W(W), .CW(CW)) u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (fcs_seed),
    .fold  (fcs_step),
    .octet (buf_data),
    .acc   (fcs_acc)
  );

  hdlc_tx_serializer #(.W(W), .CW(CW), .RUN(RUN_LIMIT)) u_ser (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .buf_valid     (buf_valid),
    .buf_data      (buf_data),
    .fcs_acc       (fcs_acc),
    .line_bit      (line_bit),
    .take          (take),
    .fcs_seed      (fcs_seed),
    .fcs_step      (fcs_step),
    .closing       (closing),
    .cur_sym       (cur_sym),
    .eof_evt       (eof_evt),
    .flag_done_evt (flag_done_evt),
    .stuff_evt     (stuff_evt)
  );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
  import hdlc_tx_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic host_cts,
  input logic line_bit,
  input logic buf_valid,
  input logic closing,
  input logic eof_evt,
  input logic flag_done_evt,
  input logic stuff_evt,
  input sym_e cur_sym
);

  logic       en_q;
  logic [2:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= '0;
    end else begin
      en_q <= bit_en;
      if (en_q) begin
        if (!line_bit)          run_q <= '0;
        else if (run_q != 3'd7) run_q <= run_q + 1'b1;
      end
    end
  end

  a_r2_full_blocks_cts: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> !host_cts);

  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && host_cts) |=> buf_valid);

  a_r3_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_evt |=> !line_bit);

  a_r3_no_seven_ones: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < 3'd7);

  a_r5_eof_then_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |=> (cur_sym == SYM_FCS_LO) && closing);

  a_r6_closing_blocks_cts: assert property (@(posedge clk) disable iff (!rst_n)
    closing |-> !host_cts);

  a_r6_release_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_done_evt && closing) |=> !closing);

  a_r1_idle_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_done_evt && !buf_valid) |=> (cur_sym == SYM_FLAG));

  a_r9_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_bit));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_en        (bit_en),
  .in_valid      (in_valid),
  .host_cts      (host_cts),
  .line_bit      (line_bit),
  .buf_valid     (buf_valid),
  .closing       (closing),
  .eof_evt       (eof_evt),
  .flag_done_evt (flag_done_evt),
  .stuff_evt     (stuff_evt),
  .cur_sym       (cur_sym)
);

// File: tb/hdlc_tx_framer_tb.sv
`timescale 1ns/1ps
module hdlc_tx_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       host_cts;
  logic       line_bit;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hdlc_tx_framer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .host_cts (host_cts),
    .line_bit (line_bit)
  );

  // ---------- CRC restated: non-reflected register, x^16+x^12+x^5+1 ----------
  function automatic logic [15:0] crc_nr(input logic [15:0] r, input logic [7:0] b);
    logic [15:0] x;
    logic        fb;
    x = r;
    for (int i = 0; i < 8; i++) begin
      fb = x[15] ^ b[i];
      x  = x << 1;
      if (fb) x = x ^ 16'h1021;
    end
    return x;
  endfunction

  function automatic logic [15:0] fcs_of(input logic [15:0] r);
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = r[15-i];
    return ~v;
  endfunction

  // ---------- bit strobe generator ----------
  int bitp = 4;
  int en_ctr = 0;
  always @(negedge clk) begin
    bit_en = (en_ctr >= bitp - 1);
    en_ctr = (en_ctr >= bitp - 1) ? 0 : en_ctr + 1;
  end

  // ---------- cycle reference model ----------
  bit   m_bits[$];
  int   m_kind;
  int   m_ones;
  bit   m_line;
  bit   m_bufv;
  logic [7:0]  m_buf;
  bit   m_closing;
  logic [15:0] m_r;
  bit   en_seen;

  task automatic push_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) m_bits.push_back(v[i]);
  endtask

  task automatic model_reset();
    m_bits.delete();
    push_octet(8'h7E);
    m_kind = 0; m_ones = 0; m_line = 1'b1;
    m_bufv = 1'b0; m_buf = 8'h00; m_closing = 1'b0; m_r = 16'hFFFF;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit   cts_old, acc, took, b;
    logic [15:0] f;
    en_seen = bit_en;
    if (!rst_n) begin
      model_reset();
    end else begin
      cts_old = !m_bufv && !m_closing;
      acc  = in_valid && cts_old;
      took = 1'b0;
      if (bit_en) begin
        if (m_ones == 5) begin
          m_line = 1'b0; m_ones = 0;
        end else begin
          b = m_bits.pop_front();
          m_line = b;
          m_ones = (m_kind != 0 && b) ? m_ones + 1 : 0;
          if (m_bits.size() == 0) begin
            case (m_kind)
              0: begin
                m_closing = 1'b0;
                if (m_bufv) begin
                  push_octet(m_buf); m_r = crc_nr(16'hFFFF, m_buf); m_kind = 1; took = 1'b1;
                end else push_octet(8'h7E);
              end
              1: begin
                if (m_bufv) begin
                  push_octet(m_buf); m_r = crc_nr(m_r, m_buf); took = 1'b1;
                end else begin
                  f = fcs_of(m_r); push_octet(f[7:0]); m_kind = 2; m_closing = 1'b1;
                end
              end
              2: begin f = fcs_of(m_r); push_octet(f[15:8]); m_kind = 3; end
              default: begin push_octet(8'h7E); m_kind = 0; end
            endcase
          end
        end
      end
      if (took) m_bufv = 1'b0;
      if (acc) begin m_bufv = 1'b1; m_buf = in_data; end
    end
  end

  // ---------- receive-side deframer ----------
  bit         fb_q[$];
  int         rx_ones = 0;
  int         n_flags = 0;
  int         n_frames = 0;
  logic [7:0] exp_data[$];
  int         exp_len[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic handle_frame();
    int n, len;
    logic [7:0] by;
    logic [15:0] r;
    logic [15:0] got;
    n = fb_q.size();
    n_frames++;
    check((n % 8) == 0 && n >= 24, "R3", "frame bit length", n, 24);
    if ((n % 8) != 0 || n < 24) return;
    len = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
    check(len == n / 8 - 2, "R5", "frame octet count", n / 8 - 2, len);
    r = 16'hFFFF;
    for (int k = 0; k < n / 8 - 2; k++) begin
      for (int i = 0; i < 8; i++) by[i] = fb_q[8*k+i];
      r = crc_nr(r, by);
      if (exp_data.size() > 0) begin
        logic [7:0] e;
        e = exp_data.pop_front();
        check(by == e, "R8", "payload octet", by, e);
      end
    end
    for (int i = 0; i < 16; i++) got[i] = fb_q[n - 16 + i];
    check(got == fcs_of(r), "R4", "check sequence", got, fcs_of(r));
  endtask

  bit started = 1'b0;
  always @(negedge clk) begin
    if (rst_n && started) begin
      check(line_bit == m_line, "R1 R3 R5 R8 R9", "line_bit", line_bit, m_line);
      check(host_cts == (!m_bufv && !m_closing), "R2 R6 R7", "host_cts",
            host_cts, !m_bufv && !m_closing);
      if (en_seen) begin
        if (line_bit) begin
          rx_ones++;
          fb_q.push_back(1'b1);
          if (rx_ones >= 7) check(1'b0, "R3", "seven ones on line", rx_ones, 6);
        end else if (rx_ones == 5) begin
          rx_ones = 0;
        end else if (rx_ones == 6) begin
          rx_ones = 0;
          n_flags++;
          if (fb_q.size() >= 7) for (int i = 0; i < 7; i++) void'(fb_q.pop_back());
          if (fb_q.size() > 0) handle_frame();
          fb_q.delete();
        end else begin
          rx_ones = 0;
          fb_q.push_back(1'b0);
        end
      end
    end
  end

  // ---------- host driver ----------
  int sent_frames = 0;

  task automatic send_octet(input logic [7:0] v);
    @(negedge clk);
    while (!host_cts) @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    exp_data.push_back(v);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic end_frame(input int n);
    exp_len.push_back(n);
    sent_frames++;
    repeat (24 * bitp) @(negedge clk);
    while (!host_cts) @(negedge clk);
  endtask

  task automatic run_patterns();
    for (int i = 0; i < 5; i++) send_octet(8'(8'h01 + i));      end_frame(5);
    for (int i = 0; i < 4; i++) send_octet(8'hFF);              end_frame(4);
    for (int i = 0; i < 3; i++) send_octet(8'h00);              end_frame(3);
    for (int i = 0; i < 3; i++) send_octet(8'h7E);              end_frame(3);
    send_octet(8'hF8); send_octet(8'h1F); send_octet(8'hF8);    end_frame(3);
    send_octet(8'hAB);                                          end_frame(1);
    send_octet(8'h3C);                                          end_frame(1);
    for (int i = 0; i < 9; i++) send_octet(8'(8'h31 + i));      end_frame(9);
  endtask

  // ---------- main sequence ----------
  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    check(line_bit == 1'b1, "R9", "reset line_bit", line_bit, 1);
    check(host_cts == 1'b1, "R9", "reset host_cts", host_cts, 1);
    r = 16'hFFFF;
    for (int i = 0; i < 9; i++) r = crc_nr(r, 8'(8'h31 + i));
    check(fcs_of(r) == 16'h906E, "R4", "known string check value", fcs_of(r), 16'h906E);
    rst_n = 1'b1;
    started = 1'b1;
    repeat (40 * bitp) @(negedge clk);
    check(n_frames == 0, "R1", "no frame while idle", n_frames, 0);
    check(n_flags >= 3, "R1", "idle flags seen", n_flags, 3);
    run_patterns();
    bitp = 1;
    repeat (20) @(negedge clk);
    run_patterns();
    repeat (40) @(negedge clk);
    check(n_frames == sent_frames, "R5", "frames closed by underrun", n_frames, sent_frames);
    check(exp_data.size() == 0, "R8", "all payload delivered", exp_data.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule